// File: doc/BRIEF.md
# Serial Message Identifier Matcher

This block checks the opening bytes of a received serial frame against a bank of stored identifier patterns. Twenty byte-wide pattern registers are loaded through a simple write port. The bank is read either as five 4-byte identifiers or as ten 2-byte identifiers. Each received bit is compared against the matching bit of every identifier in the same cycle. Every identifier keeps its own survival flag, which is cleared on the first bit that disagrees with it.

A configurable window limits the comparison. It starts at a chosen byte position and covers a chosen number of bytes. Bits before the window are counted but not compared. When the last bit of the window arrives, the block raises a one-cycle match pulse if at least one identifier survived. If every identifier has dropped out, a one-cycle fail pulse is raised as soon as the last one drops. The receiver uses that pulse to abandon the frame and wait for the next frame start.

Configuration and pattern contents are sampled at each frame start. A scan is therefore never disturbed by writes made during a frame. The control state machine has four states:
- ST_IDLE: disabled, or no frame seen yet.
- ST_SKIP: counting bits that come before the window.
- ST_COMPARE: comparing bits inside the window.
- ST_DONE: a result has been given, and the block waits for the next frame start.

The transitions are:
- Any state goes to ST_IDLE while the enable input is low.
- Any state goes to ST_SKIP or ST_COMPARE on a frame start. The choice depends on whether the window starts at byte 0.
- ST_SKIP goes to ST_COMPARE after the last bit before the window.
- ST_COMPARE goes to ST_DONE on the last window bit, or when no identifier survives.

Top module: `msg_id_matcher`

## Requirements
- R1: After reset, match_o and fail_o are low and all twenty pattern registers hold 0x00, so an all-zero stream matches.
- R2: When wr_en is high, the write port stores wr_data into the pattern register selected by wr_addr. A write with wr_addr of 20 or more changes nothing.
- R3: With cfg_wide=1, identifier k is registers 4k..4k+3 (k = 0..4). With cfg_wide=0, identifier k is registers 2k..2k+1 (k = 0..9). In both modes the lower index is the first byte received, and each byte arrives MSB first.
- R4: Bit positions count from 0, beginning with the first valid bit after frame start. Bits in bytes before cfg_start are not compared. A cfg_start beyond the last byte of the identifier is clamped to that last byte.
- R5: The window covers cfg_len+1 bytes. Its end is clamped to the last byte of the identifier (byte 3 in 4-byte mode, byte 1 in 2-byte mode).
- R6: match_o pulses high for one cycle. The pulse comes in the cycle after the clock edge that takes the last window bit, when at least one identifier agreed on every compared bit.
- R7: fail_o pulses high for one cycle. The pulse comes in the cycle after the edge that takes the bit clearing the last surviving identifier. No further result follows until the next frame start.
- R8: While cfg_enable is low, both outputs stay low and bits and frame starts are ignored.
- R9: Pattern writes and configuration changes made during a frame do not affect that frame. They take effect at the next frame start.
- R10: A frame start restarts the scan from bit position 0, even in the middle of a frame. A bit presented in the same cycle as frame_start is ignored.
- R11: match_o and fail_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern register write strobe |
| wr_addr | input | 5 | Pattern register index |
| wr_data | input | 8 | Pattern register write data |
| cfg_enable | input | 1 | Scanning enable |
| cfg_wide | input | 1 | 1: 4-byte identifiers, 0: 2-byte identifiers |
| cfg_start | input | 2 | First compared byte position |
| cfg_len | input | 2 | Window length in bytes minus one |
| frame_start | input | 1 | Frame start strobe |
| bit_valid | input | 1 | Serial bit qualifier |
| bit_in | input | 1 | Serial data bit |
| match_o | output | 1 | One-cycle match pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
The hardest situation to reach is a window whose clamped start and end land on the same byte. It must be combined with a pattern or configuration write that arrives in the middle of that window's frame. Only then do a wrong clamp and a too-early capture both change the reported result. The stimulus builds this case on purpose. It sets an out-of-range start in 2-byte mode and sends a leading byte that matches no identifier. It also writes a new pattern and a new configuration between the bytes of a scan that is already running. Frames are also restarted part-way through, and a bit is sent in the same cycle as frame start. This confirms that the surviving flags are re-armed from a clean state.

// File: rtl/mid_pkg.sv
package mid_pkg;
    localparam int WIDE_BYTES   = 4;
    localparam int NARROW_BYTES = 2;
    localparam int BSEL_W       = $clog2(WIDE_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SKIP,
        ST_COMPARE,
        ST_DONE
    } scan_state_t;
endpackage

// File: rtl/mid_pattern_bank.sv
module mid_pattern_bank #(
    parameter int N_REGS = 20,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              capture,
    output logic [BYTE_W-1:0] shadow_o [N_REGS]
);
    logic [BYTE_W-1:0] live_q [N_REGS];

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        // Writable copy, loaded by the write port.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                live_q[i] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                live_q[i] <= wr_data;
        end

        // Working copy, frozen for the length of a frame.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_o[i] <= '0;
            else if (capture)
                shadow_o[i] <= live_q[i];
        end
    end
endmodule

// File: rtl/mid_slot_cmp.sv
module mid_slot_cmp
    import mid_pkg::*;
#(
    parameter int N_REGS = 20,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 5,
    parameter int OFF_W  = 3,
    parameter int SLOT   = 0
) (
    input  logic [BYTE_W-1:0] bank_i [N_REGS],
    input  logic              wide_i,
    input  logic [BSEL_W-1:0] byte_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              bit_i,
    output logic              miss_o
);
    int                unsigned reg_idx;
    logic [OFF_W-1:0]  bit_sel;

    // Offset 0 is the first bit received, which is the MSB (BYTE_W is a power of two).
    assign bit_sel = ~off_i;

    always_comb begin
        reg_idx = wide_i ? (SLOT * WIDE_BYTES + int'(byte_i))
                         : (SLOT * NARROW_BYTES + int'(byte_i));
        miss_o  = 1'b0;
        if (reg_idx < N_REGS)
            miss_o = bank_i[reg_idx[ADDR_W-1:0]][bit_sel] ^ bit_i;
    end
endmodule

// File: rtl/mid_scan_fsm.sv
module mid_scan_fsm
    import mid_pkg::*;
#(
    parameter int N_SLOTS = 10,
    parameter int N_WIDE  = 5,
    parameter int OFF_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               frame_start,
    input  logic               bit_valid,
    input  logic               cfg_wide,
    input  logic [BSEL_W-1:0]  cfg_start,
    input  logic [BSEL_W-1:0]  cfg_len,
    input  logic [N_SLOTS-1:0] miss_i,
    output logic               capture,
    output logic               wide_q,
    output logic [BSEL_W-1:0]  byte_sel,
    output logic [OFF_W-1:0]   bit_off,
    output logic               match_o,
    output logic               fail_o
);
    localparam int CNT_W = OFF_W + BSEL_W;

    scan_state_t        state_q, state_d;
    logic [CNT_W-1:0]   pos_q, pos_inc;
    logic [BSEL_W-1:0]  start_q, end_q, last_byte, start_d, end_d;
    logic [BSEL_W:0]    end_sum;
    logic [N_SLOTS-1:0] alive_q, alive_nxt, alive_init;
    logic               last_bit, take_bit;

    assign capture   = enable && frame_start;
    assign byte_sel  = pos_q[CNT_W-1:OFF_W];
    assign bit_off   = pos_q[OFF_W-1:0];
    assign pos_inc   = pos_q + CNT_W'(1);
    assign last_bit  = (byte_sel == end_q) && (&bit_off);
    assign alive_nxt = alive_q & ~miss_i;
    assign take_bit  = enable && !frame_start && bit_valid;

    // Clamp the window to the identifier width selected at frame start.
    always_comb begin
        last_byte = cfg_wide ? BSEL_W'(WIDE_BYTES - 1) : BSEL_W'(NARROW_BYTES - 1);
        start_d   = (cfg_start > last_byte) ? last_byte : cfg_start;
        end_sum   = {1'b0, start_d} + {1'b0, cfg_len};
        end_d     = (end_sum > {1'b0, last_byte}) ? last_byte : end_sum[BSEL_W-1:0];
        for (int k = 0; k < N_SLOTS; k++)
            alive_init[k] = cfg_wide ? (k < N_WIDE) : 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (!enable)
            state_d = ST_IDLE;
        else if (frame_start)
            state_d = (start_d == '0) ? ST_COMPARE : ST_SKIP;
        else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_SKIP:    if (bit_valid && (pos_inc == {start_q, OFF_W'(0)}))
                                state_d = ST_COMPARE;
                ST_COMPARE: if (bit_valid && (last_bit || (alive_nxt == '0)))
                                state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Position counter, window limits and per-identifier survival flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            start_q <= '0;
            end_q   <= '0;
            wide_q  <= 1'b0;
            alive_q <= '0;
        end else if (capture) begin
            pos_q   <= '0;
            start_q <= start_d;
            end_q   <= end_d;
            wide_q  <= cfg_wide;
            alive_q <= alive_init;
        end else if (take_bit && (state_q == ST_SKIP || state_q == ST_COMPARE)) begin
            pos_q <= pos_inc;
            if (state_q == ST_COMPARE)
                alive_q <= alive_nxt;
        end
    end

    // Result pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            fail_o  <= 1'b0;
        end else begin
            match_o <= take_bit && (state_q == ST_COMPARE) && last_bit && (alive_nxt != '0);
            fail_o  <= take_bit && (state_q == ST_COMPARE) && (alive_nxt == '0);
        end
    end
endmodule

// File: rtl/msg_id_matcher.sv
module msg_id_matcher
    import mid_pkg::*;
#(
    parameter int N_REGS = 20,
    parameter int BYTE_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        cfg_enable,
    input  logic        cfg_wide,
    input  logic [1:0]  cfg_start,
    input  logic [1:0]  cfg_len,
    input  logic        frame_start,
    input  logic        bit_valid,
    input  logic        bit_in,
    output logic        match_o,
    output logic        fail_o
);
    localparam int ADDR_W  = $clog2(N_REGS);
    localparam int OFF_W   = $clog2(BYTE_W);
    localparam int N_SLOTS = N_REGS / NARROW_BYTES;
    localparam int N_WIDE  = N_REGS / WIDE_BYTES;

    logic [BYTE_W-1:0]  bank [N_REGS];
    logic               capture, wide_q;
    logic [BSEL_W-1:0]  byte_sel;
    logic [OFF_W-1:0]   bit_off;
    logic [N_SLOTS-1:0] miss;

    mid_pattern_bank #(.N_REGS(N_REGS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (ADDR_W'(wr_addr)),
        .wr_data  (BYTE_W'(wr_data)),
        .capture  (capture),
        .shadow_o (bank)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        mid_slot_cmp #(.N_REGS(N_REGS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
                       .OFF_W(OFF_W), .SLOT(s)) u_cmp (
            .bank_i (bank),
            .wide_i (wide_q),
            .byte_i (byte_sel),
            .off_i  (bit_off),
            .bit_i  (bit_in),
            .miss_o (miss[s])
        );
    end

    mid_scan_fsm #(.N_SLOTS(N_SLOTS), .N_WIDE(N_WIDE), .OFF_W(OFF_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .frame_start (frame_start),
        .bit_valid   (bit_valid),
        .cfg_wide    (cfg_wide),
        .cfg_start   (cfg_start),
        .cfg_len     (cfg_len),
        .miss_i      (miss),
        .capture     (capture),
        .wide_q      (wide_q),
        .byte_sel    (byte_sel),
        .bit_off     (bit_off),
        .match_o     (match_o),
        .fail_o      (fail_o)
    );
endmodule

// File: rtl/mid_checker.sv
module mid_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic frame_start,
    input logic bit_valid,
    input logic match_o,
    input logic fail_o
);
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_o && fail_o)); // R11
    AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o); // R6
    AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o); // R7
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!match_o && !fail_o)); // R8
    AST_RESULT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o || fail_o) |-> $past(bit_valid && !frame_start)); // R10
endmodule

bind msg_id_matcher mid_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .frame_start (frame_start),
    .bit_valid   (bit_valid),
    .match_o     (match_o),
    .fail_o      (fail_o)
);

// File: tb/msg_id_matcher_tb.sv
module msg_id_matcher_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cfg_enable = 1'b0, cfg_wide = 1'b1;
    logic [1:0] cfg_start = '0, cfg_len = 2'd3;
    logic       frame_start = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
    logic       match_o, fail_o;

    int    checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_id_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_enable(cfg_enable), .cfg_wide(cfg_wide), .cfg_start(cfg_start), .cfg_len(cfg_len),
        .frame_start(frame_start), .bit_valid(bit_valid), .bit_in(bit_in),
        .match_o(match_o), .fail_o(fail_o)
    );

    // Behavioural reference model
    int live [20];
    int shad [20];
    bit alive [10];
    int m_phase = 0;  // 0 idle, 1 scanning, 2 finished
    int m_w = 4, m_s = 0, m_e = 0, m_pos = 0, nid = 0, by = 0, ebit = 0;
    bit any_alive = 0;
    bit exp_m = 0, exp_f = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 20; i++) begin live[i] = 0; shad[i] = 0; end
            m_phase = 0; exp_m = 0; exp_f = 0;
        end else begin
            exp_m = 0; exp_f = 0;
            if (!cfg_enable) m_phase = 0;
            else if (frame_start) begin
                for (int i = 0; i < 20; i++) shad[i] = live[i];
                m_w = cfg_wide ? 4 : 2;
                m_s = (int'(cfg_start) > m_w - 1) ? m_w - 1 : int'(cfg_start);
                m_e = m_s + int'(cfg_len);
                if (m_e > m_w - 1) m_e = m_w - 1;
                nid = 20 / m_w;
                for (int k = 0; k < 10; k++) alive[k] = (k < nid);
                m_pos = 0; m_phase = 1;
            end else if (m_phase == 1 && bit_valid) begin
                by = m_pos / 8;
                if (by >= m_s) begin
                    any_alive = 0;
                    for (int k = 0; k < 10; k++) begin
                        if (alive[k]) begin
                            ebit = (shad[k*m_w + by] >> (7 - m_pos % 8)) & 1;
                            if (ebit != int'(bit_in)) alive[k] = 0;
                        end
                        any_alive = any_alive | alive[k];
                    end
                    if (m_pos == m_e * 8 + 7) begin
                        exp_m = any_alive; exp_f = !any_alive; m_phase = 2;
                    end else if (!any_alive) begin
                        exp_f = 1; m_phase = 2;
                    end
                end
                m_pos++;
            end
            if (wr_en && wr_addr < 20) live[wr_addr] = int'(wr_data);
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (match_o !== exp_m || fail_o !== exp_f) begin
            fails++;
            $display("FAIL %s: match/fail actual %b/%b expected %b/%b at %0t",
                     cur_req, match_o, fail_o, exp_m, exp_f, $time);
        end
    end

    task automatic step(input logic fs, input logic v, input logic b);
        @(negedge clk);
        frame_start = fs; bit_valid = v; bit_in = b; wr_en = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        frame_start = 1'b0; bit_valid = 1'b0; wr_en = 1'b1;
        wr_addr = 5'(a); wr_data = 8'(d);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit gap);
        for (int i = 7; i >= 0; i--) begin
            step(1'b0, 1'b1, v[i]);
            if (gap && i == 4) step(1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic setcfg(input logic w, input int s, input int l);
        @(negedge clk);
        wr_en = 1'b0; frame_start = 1'b0; bit_valid = 1'b0;
        cfg_wide = w; cfg_start = 2'(s); cfg_len = 2'(l);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (match_o !== 1'b0 || fail_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset outputs actual %b/%b expected 0/0", match_o, fail_o);
        end
        rst_n = 1'b1;
        cfg_enable = 1'b1;

        // R1: default all-zero patterns match a zero stream
        cur_req = "R1"; setcfg(1, 0, 3);
        step(1, 0, 0); repeat (4) send_byte(8'h00, 0); idle(3);

        // R2 R3 R6: 4-byte identifier 2 in regs 8..11, write beyond range
        cur_req = "R2"; wr(8, 'hDE); wr(9, 'hAD); wr(10, 'hBE); wr(11, 'hEF); wr(25, 'hFF);
        cur_req = "R3_R6"; step(1, 0, 0);
        send_byte(8'hDE, 1); send_byte(8'hAD, 0); send_byte(8'hBE, 0); send_byte(8'hEF, 1);
        send_byte(8'h55, 0); idle(2);

        // R7: wrong third byte fails early, later bits ignored
        cur_req = "R7"; step(1, 0, 0);
        send_byte(8'hDE, 0); send_byte(8'hAD, 0); send_byte(8'h12, 0); send_byte(8'hEF, 0); idle(2);

        // R3: 2-byte identifier 7 in regs 14,15
        cur_req = "R3"; wr(14, 'h5A); wr(15, 'hC3); setcfg(0, 0, 1);
        step(1, 0, 0); send_byte(8'h5A, 0); send_byte(8'hC3, 1); idle(2);
        step(1, 0, 0); send_byte(8'h5A, 0); send_byte(8'hC2, 0); idle(2);

        // R4: 4-byte, start byte 1, two bytes, leading garbage skipped
        cur_req = "R4"; setcfg(1, 1, 1);
        step(1, 0, 0); send_byte(8'h99, 0); send_byte(8'hAD, 0); send_byte(8'hBE, 0);
        send_byte(8'h00, 0); idle(2);

        // R4 R5: 2-byte, start 3 clamps to byte 1, end clamps to byte 1
        cur_req = "R4_R5"; setcfg(0, 3, 3);
        step(1, 0, 0); send_byte(8'hFF, 0); send_byte(8'hC3, 0); idle(2);
        step(1, 0, 0); send_byte(8'hFF, 0); send_byte(8'h3C, 0); idle(2);

        // R5: 4-byte start 2 length 4 clamps to byte 3
        cur_req = "R5"; setcfg(1, 2, 3);
        step(1, 0, 0); send_byte(8'h00, 0); send_byte(8'h00, 0);
        send_byte(8'hBE, 0); send_byte(8'hEF, 0); send_byte(8'h77, 0); idle(2);

        // R8: disabled, frames and bits ignored
        cur_req = "R8"; cfg_enable = 1'b0; setcfg(1, 0, 3);
        step(1, 0, 0); send_byte(8'hDE, 0); send_byte(8'hAD, 0); send_byte(8'hBE, 0);
        send_byte(8'hEF, 0); idle(2);
        send_byte(8'h00, 0); idle(2);
        cfg_enable = 1'b1;

        // R9: writes and config changes mid-frame wait for the next frame start
        cur_req = "R9"; step(1, 0, 0); send_byte(8'hDE, 0);
        wr(10, 'h11); setcfg(0, 1, 0);
        send_byte(8'hAD, 0); send_byte(8'hBE, 0); send_byte(8'hEF, 0); idle(2);
        step(1, 0, 0); send_byte(8'h00, 0); send_byte(8'hAD, 0); idle(2);

        // R10: restart mid-frame, bit on frame-start cycle ignored
        cur_req = "R10"; setcfg(1, 0, 3); wr(10, 'hBE);
        step(1, 0, 0); send_byte(8'hDE, 0); send_byte(8'h01, 0);
        step(1, 1, 1); send_byte(8'hDE, 0); send_byte(8'hAD, 0);
        step(1, 0, 0); send_byte(8'hDE, 0); send_byte(8'hAD, 0);
        send_byte(8'hBE, 0); send_byte(8'hEF, 0); idle(3);

        // R11: covered by every clock compare of both outputs
        cur_req = "R11"; idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule